// File: doc/BRIEF.md
# Reply Bus Transfer Launcher

This block sits at the exit of a memory controller and puts finished reply transactions onto the system bus. For each reply it works out the transfer length in bus beats. A reply that bypasses the cache is sized from its byte count. A cacheable reply always moves a whole line. The block then either starts driving the bus at once or asks the bus arbiter for ownership.

The shortcut applies only when nothing is waiting, the controller already holds bus mastership, and the bus is known to stay free long enough for the whole transfer. Any other reply joins a small first-in-first-out list of waiters. The waiters ask for the bus one at a time: the next one asks only after the previous one has been granted and its transfer has finished. While a transfer runs, the block counts it down in controller clocks. On the final clock it flags whether the transfer was an I/O reply (uncached) or a normal line reply (cached).

Top module: `reply_launcher`

## Requirements
- R1: An uncached reply of S bytes takes ceil(S / BUS_BYTES) beats, and a size of zero is taken as one beat.
- R2: A cached reply takes LINE_BYTES / BUS_BYTES beats whatever its size field holds.
- R3: An accepted reply starts on the next clock (xfer_start high, arb_req low) when all of these hold: the waiter list is empty, no transfer is running, bus_master is high, and idle_horizon >= beats * RATIO. The comparison includes equality.
- R4: Any other accepted reply is appended to the waiter list. arb_req is high whenever the list is non-empty and no transfer is running.
- R5: Waiters are launched in arrival order. A reply that arrives while waiters exist is queued even if the shortcut conditions hold.
- R6: arb_grant while arb_req is high launches the oldest waiter on the next clock, with that waiter's beat count on xfer_cycles. arb_grant while arb_req is low has no effect. arb_req is low in every cycle that xfer_start is high.
- R7: The next waiter raises arb_req only after the running transfer has ended, so two xfer_start pulses are never adjacent.
- R8: A transfer of B beats lasts B * RATIO clocks, counting the xfer_start cycle as the first. last_io (uncached) or last_data (cached) is high for exactly its final clock, and never both.
- R9: in_ready is low while DEPTH waiters are held, and no reply is accepted then.
- R10: After reset in_ready is high and arb_req, xfer_start, last_io and last_data are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A reply descriptor is offered |
| in_ready | output | 1 | The block can take a descriptor |
| in_size | input | SIZE_W | Reply size in bytes |
| in_uncached | input | 1 | 1: uncached (I/O) reply, 0: cached line reply |
| bus_master | input | 1 | Controller currently owns the bus |
| idle_horizon | input | HOR_W | Clocks for which the bus is known to stay free |
| arb_req | output | 1 | Request for bus ownership |
| arb_grant | input | 1 | Ownership granted |
| xfer_start | output | 1 | One-clock strobe: a transfer begins |
| xfer_cycles | output | CYC_W | Beat count of the starting transfer |
| last_io | output | 1 | Final clock of an uncached transfer |
| last_data | output | 1 | Final clock of a cached transfer |

## Verification
The bench uses the defaults: 8-bit sizes, 8-byte beats, 64-byte lines, a clock ratio of 2 and four waiters. With these values an uncached reply runs from 1 to 32 beats and a cached one takes 8. This puts horizon thresholds from 2 to 64 clocks within reach of a 7-bit random horizon, so both sides of the R3 equality boundary come up often. A four-entry list fills within a handful of cycles when bus_master is held low, which exercises the stall of R9 and the ordering of R5.

// File: rtl/rbl_pkg.sv
// Package rbl_pkg
// Shared helpers for the reply launcher: integer arithmetic used to size
// counters from the parameters. Assumes only positive arguments.
package rbl_pkg;

    // Larger of two unsigned integers
    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Ceiling division for parameter sizing
    function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/reply_beat_calc.sv
// Module reply_beat_calc
// Combinational beat count of one reply. An uncached reply takes its byte
// size rounded up to whole beats, and a size of zero becomes one beat. A
// cached reply always takes one full line. Assumes LINE_BYTES is a multiple
// of BUS_BYTES.
module reply_beat_calc #(
    parameter int unsigned SIZE_W     = 8,
    parameter int unsigned BUS_BYTES  = 8,
    parameter int unsigned LINE_BYTES = 64,
    parameter int unsigned CYC_W      = 6
) (
    input  logic [SIZE_W-1:0] size,
    input  logic              uncached,
    output logic [CYC_W-1:0]  beats
);
    localparam int unsigned SUM_W      = SIZE_W + $clog2(BUS_BYTES) + 1;
    localparam int unsigned LINE_BEATS = LINE_BYTES / BUS_BYTES;
    localparam int unsigned SHIFT      = $clog2(BUS_BYTES);

    logic [SUM_W-1:0] padded;
    logic [SUM_W-1:0] raw;

    // Size padded so that division rounds up
    assign padded = SUM_W'(size) + SUM_W'(BUS_BYTES - 1);

    // Power-of-two beat width divides by shifting, otherwise a divider
    generate
        if ((BUS_BYTES & (BUS_BYTES - 1)) == 0) begin : g_shift
            assign raw = padded >> SHIFT;
        end else begin : g_div
            assign raw = padded / SUM_W'(BUS_BYTES);
        end
    endgenerate

    // Pick uncached or line length, never zero beats
    always_comb begin
        if (uncached) begin
            beats = (raw == '0) ? CYC_W'(1) : CYC_W'(raw);
        end else begin
            beats = CYC_W'(LINE_BEATS);
        end
    end

endmodule

// File: rtl/reply_waiter_fifo.sv
// Module reply_waiter_fifo
// First-in-first-out list of replies waiting for bus arbitration. A push
// happens only when the list is not full. A pop happens only when it is not
// empty. Both may happen in the same clock.
module reply_waiter_fifo #(
    parameter int unsigned W     = 7,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign dout  = mem[rd_ptr];

    // Store the pushed entry
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance the pointers and the occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // R9: never written while full, never read while empty
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/reply_xfer_timer.sv
// Module reply_xfer_timer
// Counts one running transfer down in controller clocks, namely beats times
// the bus clock ratio. It flags the final clock as I/O or line reply.
// Assumes load arrives only while idle.
module reply_xfer_timer #(
    parameter int unsigned CYC_W = 6,
    parameter int unsigned RATIO = 2,
    parameter int unsigned CLK_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CYC_W-1:0] load_beats,
    input  logic             load_uncached,
    output logic             busy,
    output logic             last_io,
    output logic             last_data
);
    logic [CLK_W-1:0] remain;
    logic             is_io;

    assign busy      = (remain != '0);
    assign last_io   = (remain == CLK_W'(1)) && is_io;
    assign last_data = (remain == CLK_W'(1)) && !is_io;

    // Load the transfer length or count it down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            is_io  <= 1'b0;
        end else if (load) begin
            remain <= CLK_W'(load_beats) * CLK_W'(RATIO);
            is_io  <= load_uncached;
        end else if (busy) begin
            remain <= remain - 1'b1;
        end
    end

    // R8: only one kind of final-clock flag at a time
    p_one_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({last_io, last_data}) <= 1);
    // R7: a new transfer is never loaded over a running one
    p_no_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

endmodule

// File: rtl/reply_launcher.sv
// Module reply_launcher
// Top of the reply launcher. It sizes each accepted reply and takes the
// shortcut onto the bus when mastership and idle time allow. Otherwise it
// queues the reply and requests arbitration for the oldest waiter, one
// transfer at a time. Assumes arb_grant is sampled only while arb_req is
// high and that idle_horizon is counted in controller clocks.
module reply_launcher #(
    parameter int unsigned SIZE_W     = 8,
    parameter int unsigned BUS_BYTES  = 8,
    parameter int unsigned LINE_BYTES = 64,
    parameter int unsigned RATIO      = 2,
    parameter int unsigned DEPTH      = 4,
    parameter int unsigned HOR_W      = 12,
    localparam int unsigned MAX_BEATS = rbl_pkg::max_u(
        rbl_pkg::ceil_div((1 << SIZE_W) - 1, BUS_BYTES), LINE_BYTES / BUS_BYTES),
    localparam int unsigned CYC_W     = $clog2(MAX_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SIZE_W-1:0] in_size,
    input  logic              in_uncached,
    input  logic              bus_master,
    input  logic [HOR_W-1:0]  idle_horizon,
    output logic              arb_req,
    input  logic              arb_grant,
    output logic              xfer_start,
    output logic [CYC_W-1:0]  xfer_cycles,
    output logic              last_io,
    output logic              last_data
);
    localparam int unsigned CLK_W = $clog2(MAX_BEATS * RATIO + 1);
    localparam int unsigned ENT_W = CYC_W + 1;

    logic [CYC_W-1:0] new_beats;
    logic             accept, fast, take, push, launch, busy;
    logic             q_empty, q_full;
    logic [ENT_W-1:0] head;
    logic [CYC_W-1:0] launch_beats;
    logic             launch_uc;
    logic [31:0]      need_clk;

    reply_beat_calc #(
        .SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES),
        .LINE_BYTES(LINE_BYTES), .CYC_W(CYC_W)
    ) u_calc (
        .size(in_size), .uncached(in_uncached), .beats(new_beats)
    );

    reply_waiter_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .din({in_uncached, new_beats}),
        .pop(take), .dout(head),
        .empty(q_empty), .full(q_full)
    );

    reply_xfer_timer #(.CYC_W(CYC_W), .RATIO(RATIO), .CLK_W(CLK_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(launch), .load_beats(launch_beats), .load_uncached(launch_uc),
        .busy(busy), .last_io(last_io), .last_data(last_data)
    );

    // Decide between shortcut, queueing and granted launch
    always_comb begin
        need_clk     = 32'(new_beats) * RATIO;
        in_ready     = !q_full;
        accept       = in_valid && in_ready;
        fast         = accept && q_empty && !busy && bus_master &&
                       (32'(idle_horizon) >= need_clk);
        arb_req      = !q_empty && !busy;
        take         = arb_req && arb_grant;
        push         = accept && !fast;
        launch       = fast || take;
        launch_beats = fast ? new_beats   : head[CYC_W-1:0];
        launch_uc    = fast ? in_uncached : head[ENT_W-1];
    end

    // Register the start strobe and its beat count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_start  <= 1'b0;
            xfer_cycles <= '0;
        end else begin
            xfer_start <= launch;
            if (launch) xfer_cycles <= launch_beats;
        end
    end

    // R6: a granted request launches on the next clock
    p_grant_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req && arb_grant) |=> xfer_start);
    // R6: the request is low while a transfer starts
    p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !arb_req);
    // R7: starts are never back to back
    p_no_adjacent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);
    // R1: a started transfer has at least one beat
    p_nonzero_beats_r1: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (xfer_cycles != '0));
    // R9: a full list holds the input off
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !in_ready);

endmodule

// File: tb/sim_reply_launcher.sv
module sim_reply_launcher;
    localparam int SIZE_W = 8, BUS_BYTES = 8, LINE_BYTES = 64, RATIO = 2;
    localparam int DEPTH = 4, HOR_W = 12, CYC_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_uncached = 1'b0, bus_master = 1'b0, arb_grant = 1'b0;
    logic [SIZE_W-1:0] in_size = '0;
    logic [HOR_W-1:0]  idle_horizon = '0;
    logic in_ready, arb_req, xfer_start, last_io, last_data;
    logic [CYC_W-1:0] xfer_cycles;

    int n_chk = 0, n_bad = 0;
    int q_cyc[$];
    bit q_uc[$];
    int m_rem = 0, m_scyc = 0;
    bit m_uc = 0, m_start = 0;

    always #5 clk = ~clk;

    reply_launcher u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_size(in_size), .in_uncached(in_uncached), .bus_master(bus_master),
        .idle_horizon(idle_horizon), .arb_req(arb_req), .arb_grant(arb_grant),
        .xfer_start(xfer_start), .xfer_cycles(xfer_cycles),
        .last_io(last_io), .last_data(last_data)
    );

    // Expected beat count (R1, R2)
    function automatic int beats(int size, bit uc);
        int b;
        if (!uc) return LINE_BYTES / BUS_BYTES;
        b = (size + BUS_BYTES - 1) / BUS_BYTES;
        return (b == 0) ? 1 : b;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // One clock: compare outputs to the model, apply inputs, advance the model
    task automatic step(bit v, int sz, bit uc, bit ms, int hor, bit g);
        bit rdy, arb, acc, fast, take, st;
        int c, lc;
        bit luc;
        rdy = q_cyc.size() < DEPTH;
        arb = (q_cyc.size() > 0) && (m_rem == 0);
        chk("R9 ready", int'(in_ready), int'(rdy));
        chk("R4 R7 arb_req", int'(arb_req), int'(arb));
        chk("R3 R6 xfer_start", int'(xfer_start), int'(m_start));
        if (m_start) chk("R1 R2 R5 xfer_cycles", int'(xfer_cycles), m_scyc);
        chk("R8 last_io", int'(last_io), int'(m_rem == 1 && m_uc));
        chk("R8 last_data", int'(last_data), int'(m_rem == 1 && !m_uc));
        in_valid = v; in_size = SIZE_W'(sz); in_uncached = uc;
        bus_master = ms; idle_horizon = HOR_W'(hor); arb_grant = g;
        c = beats(sz, uc);
        acc = v && rdy;
        fast = acc && q_cyc.size() == 0 && ms && hor >= c * RATIO && m_rem == 0;
        take = arb && g;
        st = fast || take;
        lc = c; luc = uc;
        if (take) begin lc = q_cyc.pop_front(); luc = q_uc.pop_front(); end
        if (acc && !fast) begin q_cyc.push_back(c); q_uc.push_back(uc); end
        if (st) begin m_rem = lc * RATIO; m_uc = luc; m_scyc = lc; end
        else if (m_rem > 0) m_rem--;
        m_start = st;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 ready", int'(in_ready), 1);
        chk("R10 arb_req", int'(arb_req), 0);
        chk("R10 start", int'(xfer_start), 0);
        chk("R10 last", int'(last_io | last_data), 0);
        // R3 boundary: 20 bytes -> 3 beats, horizon 6 equals 3*2
        step(1, 20, 1, 1, 6, 0);
        repeat (8) step(0, 0, 0, 1, 0, 0);
        // R4: horizon 5 one short, request then grant (R6)
        step(1, 20, 1, 1, 5, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 1);
        repeat (8) step(0, 0, 0, 1, 0, 0);
        // R1 size zero, R2 cached with huge size, not master
        step(1, 0, 1, 0, 100, 0);
        step(1, 255, 0, 0, 100, 0);
        // R5: shortcut conditions while waiters exist still queue
        step(1, 9, 1, 1, 100, 0);
        // R9: fill list and stall
        step(1, 33, 1, 0, 0, 0);
        step(1, 40, 1, 0, 0, 0);
        step(1, 48, 0, 0, 0, 0);
        // Drain in order (R6, R7)
        repeat (120) step(0, 0, 0, 0, 0, 1);
        // R6: grant with no request has no effect
        repeat (4) step(0, 0, 0, 0, 0, 1);
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 10) < 4, $urandom % 256, $urandom % 2,
                 ($urandom % 10) < 7, $urandom % 128, $urandom % 2);
        end
        repeat (100) step(0, 0, 0, 0, 0, 1);
        summary();
    end
endmodule